// File: doc/BRIEF.md
# Reflected CRC-64 Stream Engine

This block folds a byte stream into a 64-bit cyclic redundancy check built on the reflected generator 0xC96C5795D7870F42. The register moves toward its least significant bit. Each byte enters at bit 0, least significant bit first. A message begins with a start strobe that carries a caller seed. The seed is complemented before the first byte is absorbed, and the finished register is complemented again on its way out.

Data arrives on a 32-bit word together with a byte count of 0 to 4. This lets a source pass an unaligned head, whole words and a short tail without repacking them. Byte 0 of the message sits in bits 7:0 of the word. The update for a whole beat is plain XOR logic derived from the generator, with no lookup memory. The beat that carries the last flag produces the result, and a one-cycle done pulse follows it.

Top module: `crc64_stream_engine`

## Requirements
- R1: A start strobe loads the complement of `seed` into the running register; the message then continues from that value, and a nonzero seed changes the result.
- R2: The generator is the reflected constant 0xC96C5795D7870F42 and processing is LSB first; with seed 0 the ASCII message "123456789" yields 0x995DC9BBDF1939FA.
- R3: On a valid beat with `nbytes` = n (1 to 4), exactly the n low-order bytes of `data` are absorbed, bits 7:0 first; the bytes above them have no effect on the result; `nbytes` never exceeds 4.
- R4: A valid beat with `nbytes` = 0 leaves the running register unchanged; a start beat with `nbytes` = 0 and last set returns the seed unchanged as the result.
- R5: The result is the bitwise complement of the running register after the last beat.
- R6: While `data_valid` is low, `data`, `nbytes` and `last` have no effect; the running register and `crc_out` hold.
- R7: `done` is high for exactly the cycle after each valid beat with `last` set, and `crc_out` changes only at that edge.
- R8: After reset, `done` is 0 and `crc_out` is 0.
- R9: The result depends only on the byte sequence and seed, not on how the bytes are split into beats.
- R10: When `start` and `data_valid` are both high in one cycle, the seed is applied first and the beat's bytes are then absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a message using `seed` |
| seed | input | 64 | Caller seed, used when `start` is high |
| data_valid | input | 1 | Beat qualifier |
| data | input | 32 | Message bytes, earliest byte in bits 7:0 |
| nbytes | input | 3 | Number of valid low-order bytes, 0 to 4 |
| last | input | 1 | Beat is the final one of the message |
| crc_out | output | 64 | Registered result of the latest message |
| done | output | 1 | One-cycle pulse when `crc_out` is fresh |

## Verification
The assertions assume that `nbytes` stays at or below 4 on a valid beat, and that `start` is not raised in the middle of a message. Outside a valid beat, `start` may be raised alone. The stimulus builds every beat from a byte count it clamps to the bytes still remaining, so a count above 4 never occurs. Its only idle-time start is the one placed just before a message. Idle cycles between beats drive random data, a count and a high `last`, so the checks exercise the inputs the block must ignore, while the byte count still stays within range.

// File: rtl/crc64_pkg.sv
package crc64_pkg;
  localparam int CRC_W = 64;
  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam logic [CRC_W-1:0] POLY_REFL = 64'hC96C5795D7870F42;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc64_byte_step.sv
// One byte folded into a reflected CRC register, bit by bit, LSB first.
module crc64_byte_step #(
  parameter int CRC_W = 64,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 64'hC96C5795D7870F42
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] acc;

  always_comb begin
    acc = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};
    for (int b = 0; b < BYTE_W; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/crc64_word_step.sv
// Chain of byte steps; the byte count selects how far along the chain to tap.
module crc64_word_step #(
  parameter int CRC_W = 64,
  parameter int BYTE_W = 8,
  parameter int LANES = 4,
  parameter logic [CRC_W-1:0] POLY = 64'hC96C5795D7870F42,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CNT_W-1:0]  count,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] chain [0:LANES];

  assign chain[0] = crc_in;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc64_byte_step #(
      .CRC_W (CRC_W),
      .BYTE_W(BYTE_W),
      .POLY  (POLY)
    ) u_step (
      .crc_in (chain[k]),
      .byte_in(word_in[k*BYTE_W +: BYTE_W]),
      .crc_out(chain[k+1])
    );
  end

  always_comb begin
    crc_out = chain[LANES];
    for (int k = 0; k < LANES; k++) begin
      if (count == CNT_W'(k)) crc_out = chain[k];
    end
  end
endmodule

// File: rtl/crc64_stream_engine.sv
module crc64_stream_engine
  import crc64_pkg::*;
#(
  parameter int CRC_BITS = CRC_W,
  parameter int BYTE_BITS = BYTE_W,
  parameter int NUM_LANES = LANES,
  parameter logic [CRC_BITS-1:0] POLY = POLY_REFL,
  localparam int WORD_BITS = NUM_LANES * BYTE_BITS,
  localparam int CNT_BITS = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CRC_BITS-1:0]  seed,
  input  logic                 data_valid,
  input  logic [WORD_BITS-1:0] data,
  input  logic [CNT_BITS-1:0]  nbytes,
  input  logic                 last,
  output logic [CRC_BITS-1:0]  crc_out,
  output logic                 done
);
  logic [CRC_BITS-1:0] state;
  logic [CRC_BITS-1:0] base;
  logic [CRC_BITS-1:0] stepped;

  // Seed takes effect in the same cycle as a coincident beat.
  assign base = start ? ~seed : state;

  crc64_word_step #(
    .CRC_W (CRC_BITS),
    .BYTE_W(BYTE_BITS),
    .LANES (NUM_LANES),
    .POLY  (POLY)
  ) u_word (
    .crc_in (base),
    .word_in(data),
    .count  (nbytes),
    .crc_out(stepped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= '1;
      crc_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= data_valid && last;
      if (data_valid) begin
        state <= stepped;
        if (last) crc_out <= ~stepped;
      end else if (start) begin
        state <= ~seed;
      end
    end
  end

  assert_nbytes_range_R3: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (nbytes <= CNT_BITS'(NUM_LANES)));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (data_valid && last) |=> done);

  assert_no_stray_done_R7: assert property (@(posedge clk) disable iff (rst)
    !(data_valid && last) |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(data_valid && last) |=> $stable(crc_out));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!data_valid && !start) |=> $stable(state));

  assert_zero_length_R4: assert property (@(posedge clk) disable iff (rst)
    (data_valid && last && start && nbytes == '0) |=> (crc_out == $past(seed)));

  assert_reset_values_R8: assert property (@(posedge clk)
    rst |=> (!done && crc_out == '0));
endmodule

// File: tb/sim_crc64_stream_engine.sv
`timescale 1ns/1ps
module sim_crc64_stream_engine;
  localparam real CLK_PERIOD = 8.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [63:0] seed;
  logic        data_valid;
  logic [31:0] data;
  logic [2:0]  nbytes;
  logic        last;
  logic [63:0] crc_out;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [7:0] msg [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc64_stream_engine u0 (
    .clk(clk), .rst(rst), .start(start), .seed(seed),
    .data_valid(data_valid), .data(data), .nbytes(nbytes), .last(last),
    .crc_out(crc_out), .done(done)
  );

  function automatic logic [63:0] ref_crc(input logic [63:0] sd, input int len);
    logic [63:0] c;
    c = ~sd;
    for (int i = 0; i < len; i++) begin
      c = c ^ {56'd0, msg[i]};
      for (int b = 0; b < 8; b++)
        c = c[0] ? ((c >> 1) ^ 64'hC96C5795D7870F42) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    start = 1'b0; data_valid = 1'b0; data = $urandom; nbytes = 3'($urandom_range(0, 4));
    last = 1'b1; seed = {$urandom, $urandom};
  endtask

  // mode: 0 = words of 4, 1 = single bytes, 2 = cycle 1,3,2,4
  task automatic send_msg(input logic [63:0] sd, input int len, input int mode,
                          input bit sep_start, input bit gaps, input string req);
    int pos;
    int n;
    int step;
    logic [63:0] prev;
    pos = 0; step = 0;
    prev = crc_out;
    if (sep_start) begin
      @(negedge clk);
      idle(); last = 1'b0; start = 1'b1; seed = sd;
    end
    do begin
      case (mode)
        0: n = 4;
        1: n = 1;
        default: n = (step % 4 == 0) ? 1 : (step % 4 == 1) ? 3 : (step % 4 == 2) ? 2 : 4;
      endcase
      if (n > len - pos) n = len - pos;
      @(negedge clk);
      if (pos > 0 || sep_start) chk({req, " R7 no done mid-message"}, {63'd0, done}, 64'd0);
      start = (pos == 0) && !sep_start;
      seed = start ? sd : {$urandom, $urandom};
      data_valid = 1'b1;
      data = $urandom; // upper bytes are junk (R3)
      for (int k = 0; k < 4; k++) if (k < n) data[k*8 +: 8] = msg[pos + k];
      nbytes = 3'(n);
      pos += n;
      last = (pos == len);
      step++;
      if (gaps && !last) begin
        @(negedge clk);
        idle(); last = 1'b1;
        @(negedge clk);
        chk({req, " R6 result held in gap"}, crc_out, prev);
      end
    end while (pos < len);
    @(negedge clk);
    idle(); last = 1'b0;
    chk({req, " R7 done after last"}, {63'd0, done}, 64'd1);
    chk({req, " R2 R5 R9 result"}, crc_out, ref_crc(sd, len));
    prev = crc_out;
    @(negedge clk);
    chk({req, " R7 done one cycle"}, {63'd0, done}, 64'd0);
    chk({req, " R7 result held"}, crc_out, prev);
  endtask

  task automatic load_check_string();
    string s;
    s = "123456789";
    for (int i = 0; i < 9; i++) msg[i] = s[i];
  endtask

  task automatic load_random(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 done after reset", {63'd0, done}, 64'd0);
    chk("R8 crc_out after reset", crc_out, 64'd0);
  endtask

  task automatic t_check_value();
    load_check_string();
    send_msg(64'd0, 9, 0, 1'b0, 1'b0, "R2 check string words");
    chk("R2 known check value", crc_out, 64'h995DC9BBDF1939FA);
  endtask

  task automatic t_chunking();
    load_check_string();
    send_msg(64'd0, 9, 1, 1'b0, 1'b0, "R9 R3 single bytes");
    chk("R9 single-byte split", crc_out, 64'h995DC9BBDF1939FA);
    send_msg(64'd0, 9, 2, 1'b0, 1'b0, "R9 R3 mixed counts");
    chk("R9 mixed split", crc_out, 64'h995DC9BBDF1939FA);
    load_random(23);
    send_msg(64'd0, 23, 2, 1'b0, 1'b0, "R9 R3 random mixed");
  endtask

  task automatic t_zero_length();
    @(negedge clk);
    start = 1'b1; seed = 64'h0123456789ABCDEF; data_valid = 1'b1; data = $urandom;
    nbytes = 3'd0; last = 1'b1;
    @(negedge clk);
    idle(); last = 1'b0;
    chk("R4 R1 zero-length returns seed", crc_out, 64'h0123456789ABCDEF);
    chk("R7 done on zero-length", {63'd0, done}, 64'd1);
  endtask

  task automatic t_empty_beat_mid();
    load_random(8);
    @(negedge clk);
    start = 1'b1; seed = 64'hDEADBEEF00C0FFEE; data_valid = 1'b1; nbytes = 3'd4;
    data = {msg[3], msg[2], msg[1], msg[0]}; last = 1'b0;
    @(negedge clk);
    start = 1'b0; seed = 64'd0; nbytes = 3'd0; data = $urandom;
    @(negedge clk);
    nbytes = 3'd4; data = {msg[7], msg[6], msg[5], msg[4]}; last = 1'b1;
    @(negedge clk);
    idle(); last = 1'b0;
    chk("R4 empty beat mid-message", crc_out, ref_crc(64'hDEADBEEF00C0FFEE, 8));
  endtask

  task automatic t_seeded();
    load_random(13);
    send_msg(64'hA5A5_0F0F_1234_8765, 13, 0, 1'b0, 1'b0, "R10 R1 seed with first beat");
    send_msg(64'hA5A5_0F0F_1234_8765, 13, 2, 1'b1, 1'b0, "R1 separate start");
    chk("R1 seed changes result", {63'd0, crc_out == ref_crc(64'd0, 13)}, 64'd0);
  endtask

  task automatic t_gaps();
    load_random(17);
    send_msg(64'h5555_AAAA_3333_CCCC, 17, 2, 1'b0, 1'b1, "R6 idle gaps ignored");
  endtask

  initial begin
    rst = 1'b1;
    idle(); last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_check_value();
    t_chunking();
    t_zero_length();
    t_empty_beat_mid();
    t_seeded();
    t_gaps();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule